// File: doc/BRIEF.md
# Serial-Lane Built-In Self-Test Pattern Engine

This block is the self-test source and sink for one lane of a serializer datapath. On the transmit side it emits one raw parallel word per clock. The word comes from a 7th-order pseudo-random sequence (generator x^7 + x^6 + 1), a fast toggle pattern or a slow square wave. The word is 10 bits wide in single-width operation and 20 bits wide in double-width operation. No line coding is applied: the pattern words go straight to the serializer, least significant bit first on the line.

The receive side watches the returning words while the pseudo-random pattern is selected. It synchronises itself to the incoming stream from any phase and raises a lock flag after a run of clean words. From then on it counts every wrong bit in a saturating counter. The toggle and square-wave patterns have no checker. A registered loopback-enable output follows a request input, so a harness can close or open the serial loop while a pattern runs.

Top module: `lane_bist`

## Requirements
- R1: While rst_n is low, and at the first clock after it, tx_data, lock, err_cnt and loopback_en are all zero.
- R2: With mode=1 and en high, the bits of tx_data taken LSB first obey b[n] = b[n-7] xor b[n-6] across word boundaries. A fresh period starts as if the seven preceding bits were all ones. width_sel=0 gives 10-bit words with tx_data[19:10] zero, and width_sel=1 gives 20-bit words.
- R3: The pseudo-random stream repeats after 127 bits. With 10-bit words, word k+127 equals word k.
- R4: mode=2 (fast toggle) puts out 20'h00155 with width_sel=0 and 20'h55555 with width_sel=1, so the line alternates on every bit.
- R5: mode=3 (square wave) puts out 20'h0001F with width_sel=0 (five ones, five zeros) and 20'h003FF with width_sel=1 (ten ones, ten zeros).
- R6: mode=0 drives tx_data to zero. A clock with en low also drives tx_data to zero and holds the pseudo-random position, so the next enabled word continues the sequence.
- R7: A change of mode or width_sel makes the next word the start of a fresh period and clears lock on that clock.
- R8: The checker raises lock after LOCK_WORDS (default 4) consecutive words. Each word must obey the R2 recurrence internally over bits 7..W-1 and end in a non-zero 7-bit tail. It locks from any stream phase, and a word that breaks the recurrence restarts the run.
- R9: Once locked, every received bit within the word width that differs from the predicted bit adds one to err_cnt. The count stops at 16'hFFFF. Bits above the active width are not counted.
- R10: While mode is not 1 or en is low, lock is zero and err_cnt does not change.
- R11: loopback_en equals lpbk_req delayed by one clock. Toggling it does not disturb tx_data.
- R12: In mode 1 with en high, tx_data is never all zero, because a zero register state is replaced by the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | 0 off, 1 pseudo-random, 2 fast toggle, 3 square wave |
| width_sel | input | 1 | 0 = 10-bit words, 1 = 20-bit words |
| en | input | 1 | Pattern advance enable |
| lpbk_req | input | 1 | Requested serial loopback state |
| rx_data | input | 20 | Word returned from the deserializer |
| tx_data | output | 20 | Pattern word toward the serializer |
| lock | output | 1 | Checker synchronised to the stream |
| err_cnt | output | 16 | Saturating bit-error count |
| loopback_en | output | 1 | Registered loopback enable |

## Verification
The hardest state to reach from the ports is a checker that locks at an arbitrary phase of the sequence instead of the phase the local generator happens to be in. In loopback the two are always aligned. The bench therefore cuts the loop and drives rx_data from its own model of the stream, started 37 bits into a period. Before that it feeds words that break the recurrence and confirms they never lock. It then keeps the same foreign stream going, inverted over the word, until the error counter saturates.

// File: rtl/lane_bist_pkg.sv
// Package: shared sizes, mode encoding and pure word functions for the
// lane self-test engine. Assumes the pseudo-random order and tap fit in
// the narrow word (ORD < SW).
package lane_bist_pkg;

    localparam int SW    = 10;                 // single-width word bits
    localparam int DW    = 20;                 // double-width word bits
    localparam int ORD   = 7;                  // shift-register order
    localparam int TAP   = 6;                  // second feedback tap
    localparam int CNT_W = $clog2(DW + 1);     // width of a per-word bit count

    typedef enum logic [1:0] {
        PAT_OFF  = 2'd0,
        PAT_PRBS = 2'd1,
        PAT_HF   = 2'd2,
        PAT_LF   = 2'd3
    } pat_mode_e;

    typedef struct packed {
        logic [DW-1:0]  word;
        logic [ORD-1:0] state;
    } prbs_step_t;

    // Active word length for the selected width.
    function automatic int word_len(input logic dbl);
        return dbl ? DW : SW;
    endfunction

    // Mask of the active bit lanes.
    function automatic logic [DW-1:0] word_mask(input logic dbl);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i < word_len(dbl));
        return m;
    endfunction

    // Run the shift register for one word; state[0] holds the newest bit.
    function automatic prbs_step_t prbs_run(input logic [ORD-1:0] st_in, input logic dbl);
        prbs_step_t     r;
        logic [ORD-1:0] st;
        logic           b;
        st     = st_in;
        r.word = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < word_len(dbl)) begin
                b         = st[ORD-1] ^ st[TAP-1];
                r.word[i] = b;
                st        = {st[ORD-2:0], b};
            end
        end
        r.state = st;
        return r;
    endfunction

    // Fast toggle word: even lanes one, odd lanes zero.
    function automatic logic [DW-1:0] hf_word(input logic dbl);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = (i < word_len(dbl)) && ((i % 2) == 0);
        return w;
    endfunction

    // Square wave word: first half ones, second half zeros.
    function automatic logic [DW-1:0] lf_word(input logic dbl);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = (i < word_len(dbl) / 2);
        return w;
    endfunction

    // True when every bit from ORD up obeys the recurrence inside the word.
    function automatic logic recur_ok(input logic [DW-1:0] w, input logic dbl);
        logic ok;
        ok = 1'b1;
        for (int i = ORD; i < DW; i++) begin
            if (i < word_len(dbl) && (w[i] != (w[i-ORD] ^ w[i-TAP]))) ok = 1'b0;
        end
        return ok;
    endfunction

    // Register state implied by the last ORD bits of a word.
    function automatic logic [ORD-1:0] tail_state(input logic [DW-1:0] w, input logic dbl);
        logic [ORD-1:0] s;
        for (int k = 0; k < ORD; k++) s[k] = w[word_len(dbl) - 1 - k];
        return s;
    endfunction

    // Population count of a word.
    function automatic logic [CNT_W-1:0] ones_count(input logic [DW-1:0] w);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < DW; i++) n = n + CNT_W'(w[i]);
        return n;
    endfunction

endpackage

// File: rtl/bist_cfg_track.sv
// Configuration tracker: remembers last cycle's mode and width to flag a
// change, and registers the loopback request. Assumes inputs are synchronous
// to clk.
module bist_cfg_track
    import lane_bist_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pat_mode_e mode,
    input  logic      width_sel,
    input  logic      lpbk_req,
    output logic      cfg_chg,
    output logic      loopback_en
);

    pat_mode_e mode_q;
    logic      wid_q;

    // Flag any difference between this cycle's and last cycle's configuration.
    always_comb cfg_chg = (mode != mode_q) || (width_sel != wid_q);

    // Capture configuration and loopback request every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= PAT_OFF;
            wid_q       <= 1'b0;
            loopback_en <= 1'b0;
        end else begin
            mode_q      <= mode;
            wid_q       <= width_sel;
            loopback_en <= lpbk_req;
        end
    end

endmodule

// File: rtl/bist_pattern_tx.sv
// Pattern generator: one registered word per enabled clock. A configuration
// change, even while disabled, restarts the sequence at SEED on the next
// enabled word. A zero register state is replaced by SEED.
module bist_pattern_tx
    import lane_bist_pkg::*;
#(
    parameter logic [ORD-1:0] SEED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  pat_mode_e     mode,
    input  logic          dbl,
    input  logic          cfg_chg,
    output logic [DW-1:0] tx_data
);

    logic [ORD-1:0] lfsr;
    logic           pend;
    logic           restart;
    logic [ORD-1:0] base;
    prbs_step_t     step;

    // Choose the starting state for this word and run it forward.
    always_comb begin
        restart = cfg_chg || pend;
        base    = (restart || (lfsr == '0)) ? SEED : lfsr;
        step    = prbs_run(base, dbl);
    end

    // Register the outgoing word and the generator position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr    <= SEED;
            pend    <= 1'b0;
            tx_data <= '0;
        end else if (en) begin
            pend <= 1'b0;
            case (mode)
                PAT_PRBS: begin
                    tx_data <= step.word;
                    lfsr    <= step.state;
                end
                PAT_HF: begin
                    tx_data <= hf_word(dbl);
                    lfsr    <= SEED;
                end
                PAT_LF: begin
                    tx_data <= lf_word(dbl);
                    lfsr    <= SEED;
                end
                default: begin
                    tx_data <= '0;
                    lfsr    <= SEED;
                end
            endcase
        end else begin
            tx_data <= '0;
            pend    <= pend || cfg_chg;
        end
    end

endmodule

// File: rtl/bist_prbs_rx.sv
// Pseudo-random checker: seeds from received words until LOCK_WORDS clean
// words arrive in a row, then predicts each word and counts wrong bits in a
// saturating counter. Idle unless enabled in pseudo-random mode.
module bist_prbs_rx
    import lane_bist_pkg::*;
#(
    parameter int LOCK_WORDS = 4,
    parameter int ERR_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  pat_mode_e        mode,
    input  logic             dbl,
    input  logic             cfg_chg,
    input  logic [DW-1:0]    rx_data,
    output logic             lock,
    output logic [ERR_W-1:0] err_cnt
);

    localparam int GW = $clog2(LOCK_WORDS + 1);

    logic [ORD-1:0]   chk;
    logic [GW-1:0]    good;
    prbs_step_t       pred;
    logic [ORD-1:0]   tail;
    logic             word_ok;
    logic [CNT_W-1:0] miss;
    logic [ERR_W:0]   sum;

    // Predict the word, score the received one and form the saturating sum.
    always_comb begin
        pred    = prbs_run(chk, dbl);
        tail    = tail_state(rx_data, dbl);
        word_ok = recur_ok(rx_data, dbl) && (tail != '0);
        miss    = ones_count((rx_data ^ pred.word) & word_mask(dbl));
        sum     = {1'b0, err_cnt} + {{(ERR_W + 1 - CNT_W){1'b0}}, miss};
    end

    // Track synchronisation and accumulate bit errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk     <= '0;
            good    <= '0;
            lock    <= 1'b0;
            err_cnt <= '0;
        end else if (cfg_chg || !en || (mode != PAT_PRBS)) begin
            good <= '0;
            lock <= 1'b0;
        end else if (!lock) begin
            if (word_ok) begin
                chk <= tail;
                if (good == GW'(LOCK_WORDS - 1)) begin
                    lock <= 1'b1;
                    good <= '0;
                end else begin
                    good <= good + 1'b1;
                end
            end else begin
                good <= '0;
            end
        end else begin
            chk     <= pred.state;
            err_cnt <= sum[ERR_W] ? '1 : sum[ERR_W-1:0];
        end
    end

endmodule

// File: rtl/lane_bist.sv
// Top of the lane self-test engine: configuration tracker, pattern
// generator and pseudo-random checker. Assumes rx_data is word-aligned to
// the transmitted bit order (LSB first).
module lane_bist
    import lane_bist_pkg::*;
#(
    parameter logic [ORD-1:0] SEED       = '1,
    parameter int             LOCK_WORDS = 4,
    parameter int             ERR_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             width_sel,
    input  logic             en,
    input  logic             lpbk_req,
    input  logic [DW-1:0]    rx_data,
    output logic [DW-1:0]    tx_data,
    output logic             lock,
    output logic [ERR_W-1:0] err_cnt,
    output logic             loopback_en
);

    pat_mode_e mode_e;
    logic      cfg_chg;

    // Decode the raw mode pins into the shared enumeration.
    always_comb mode_e = pat_mode_e'(mode);

    bist_cfg_track u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_e),
        .width_sel   (width_sel),
        .lpbk_req    (lpbk_req),
        .cfg_chg     (cfg_chg),
        .loopback_en (loopback_en)
    );

    bist_pattern_tx #(.SEED(SEED)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode_e),
        .dbl     (width_sel),
        .cfg_chg (cfg_chg),
        .tx_data (tx_data)
    );

    bist_prbs_rx #(.LOCK_WORDS(LOCK_WORDS), .ERR_W(ERR_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode_e),
        .dbl     (width_sel),
        .cfg_chg (cfg_chg),
        .rx_data (rx_data),
        .lock    (lock),
        .err_cnt (err_cnt)
    );

endmodule

// File: rtl/lane_bist_sva.sv
// Assertion checker for lane_bist, attached by bind. Observes ports only.
module lane_bist_sva #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             width_sel,
    input logic             en,
    input logic             lpbk_req,
    input logic [19:0]      tx_data,
    input logic             lock,
    input logic [ERR_W-1:0] err_cnt,
    input logic             loopback_en
);

    logic past_ok;

    // Mark cycles where $past refers to a post-reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R11
    loopback_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (loopback_en == $past(lpbk_req)));

    // R10
    idle_checker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || mode != 2'd1) |=> (!lock && $stable(err_cnt)));

    // R7
    cfg_change_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (mode != $past(mode) || width_sel != $past(width_sel))) |=> !lock);

    // R9
    err_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (err_cnt >= $past(err_cnt)));

    // R9
    err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> $stable(err_cnt));

    // R12
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd1) |=> (tx_data != 20'h0));

    // R4
    hf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd2 && !width_sel) |=> (tx_data == 20'h00155));

    // R5
    lf_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd3 && width_sel) |=> (tx_data == 20'h003FF));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_data == 20'h0));

endmodule

bind lane_bist lane_bist_sva #(.ERR_W(ERR_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .width_sel   (width_sel),
    .en          (en),
    .lpbk_req    (lpbk_req),
    .tx_data     (tx_data),
    .lock        (lock),
    .err_cnt     (err_cnt),
    .loopback_en (loopback_en)
);

// File: tb/lane_bist_tb.sv
module lane_bist_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        width_sel;
    logic        en;
    logic        lpbk_req;
    logic [19:0] rx_data;
    logic [19:0] tx_data;
    logic        lock;
    logic [15:0] err_cnt;
    logic        loopback_en;

    logic        rx_src;
    logic [19:0] rx_drv;
    logic [19:0] err_mask;

    int n_chk  = 0;
    int n_fail = 0;
    logic [6:0] mh;

    always #10 clk = ~clk;

    // Harness loop: either the transmitted word or a bench-driven word.
    assign rx_data = rx_src ? rx_drv : (tx_data ^ err_mask);

    lane_bist u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .width_sel   (width_sel),
        .en          (en),
        .lpbk_req    (lpbk_req),
        .rx_data     (rx_data),
        .tx_data     (tx_data),
        .lock        (lock),
        .err_cnt     (err_cnt),
        .loopback_en (loopback_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Stream model from R2: b[n] = b[n-7] ^ b[n-6], fresh period after seven ones.
    task automatic mdl_reset();
        mh = 7'h7F;
    endtask

    task automatic mdl_word(input logic dbl, output logic [19:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < (dbl ? 20 : 10); i++) begin
            b    = mh[6] ^ mh[5];
            w[i] = b;
            mh   = {mh[5:0], b};
        end
    endtask

    // Fixed-pattern vectors: [23:22] mode, [20] width_sel, [19:0] expected word.
    localparam logic [23:0] VEC [6] = '{
        {2'd2, 1'b0, 1'b0, 20'h00155},
        {2'd2, 1'b0, 1'b1, 20'h55555},
        {2'd3, 1'b0, 1'b0, 20'h0001F},
        {2'd3, 1'b0, 1'b1, 20'h003FF},
        {2'd0, 1'b0, 1'b0, 20'h00000},
        {2'd0, 1'b0, 1'b1, 20'h00000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [19:0] w;
        logic [19:0] w0;
        logic        any_zero;
        string       tag;

        rst_n = 1'b0; mode = 2'd0; width_sel = 1'b0; en = 1'b0; lpbk_req = 1'b0;
        rx_src = 1'b0; rx_drv = '0; err_mask = '0;
        repeat (3) tick();
        // R1 reset state
        check("R1 tx", 32'(tx_data), 0);
        check("R1 lock", 32'(lock), 0);
        check("R1 err", 32'(err_cnt), 0);
        check("R1 loopback", 32'(loopback_en), 0);
        rst_n = 1'b1;
        tick();
        check("R1 first clock tx", 32'(tx_data), 0);
        en = 1'b1;

        // Fixed patterns from the vector table (R4, R5, R6, R10).
        for (int v = 0; v < 6; v++) begin
            mode      = VEC[v][23:22];
            width_sel = VEC[v][20];
            case (VEC[v][23:22])
                2'd2:    tag = "R4 toggle word";
                2'd3:    tag = "R5 square word";
                default: tag = "R6 off word";
            endcase
            tick();
            check(tag, 32'(tx_data), 32'(VEC[v][19:0]));
            tick();
            check(tag, 32'(tx_data), 32'(VEC[v][19:0]));
            check("R10 no lock outside prbs", 32'(lock), 0);
        end

        // Pseudo-random single width in loopback: stream, lock, period, loopback.
        mode = 2'd1; width_sel = 1'b0;
        mdl_reset();
        any_zero = 1'b0;
        w0 = '0;
        for (int k = 0; k < 131; k++) begin
            tick();
            mdl_word(1'b0, w);
            if (k == 0) begin
                w0 = w;
                check("R7 fresh period first word", 32'(tx_data), 32'(w));
            end
            check("R2 prbs word", 32'(tx_data), 32'(w));
            if (tx_data == '0) any_zero = 1'b1;
            if (k == 3) check("R8 lock not yet", 32'(lock), 0);
            if (k == 4) check("R8 lock after run", 32'(lock), 1);
            if (k == 127) check("R3 period 127 bits", 32'(tx_data), 32'(w0));
            if (k == 50) lpbk_req = 1'b1;
            if (k == 51) check("R11 loopback on", 32'(loopback_en), 1);
            if (k == 60) lpbk_req = 1'b0;
            if (k == 61) check("R11 loopback off", 32'(loopback_en), 0);
        end
        check("R12 no zero word", 32'(any_zero), 0);
        check("R9 no false errors", 32'(err_cnt), 0);

        // Injected errors while locked (R9).
        err_mask = 20'h00004;
        tick(); mdl_word(1'b0, w);
        err_mask = '0;
        check("R9 single error", 32'(err_cnt), 1);
        err_mask = 20'h00301;
        tick(); mdl_word(1'b0, w);
        err_mask = '0;
        check("R9 three errors", 32'(err_cnt), 4);
        err_mask = 20'hFFC00;
        tick(); mdl_word(1'b0, w);
        err_mask = '0;
        check("R9 upper lanes ignored", 32'(err_cnt), 4);
        check("R9 still locked", 32'(lock), 1);

        // Pause and resume (R6, R10).
        en = 1'b0;
        tick();
        check("R6 disabled tx zero", 32'(tx_data), 0);
        check("R10 disabled unlock", 32'(lock), 0);
        tick();
        en = 1'b1;
        tick(); mdl_word(1'b0, w);
        check("R6 resume position", 32'(tx_data), 32'(w));
        for (int k = 0; k < 6; k++) begin
            tick(); mdl_word(1'b0, w);
            check("R6 resumed stream", 32'(tx_data), 32'(w));
        end
        check("R8 relock after pause", 32'(lock), 1);
        check("R10 err held over pause", 32'(err_cnt), 4);

        // Width change restarts the period (R7, R2 double width).
        width_sel = 1'b1;
        mdl_reset();
        tick(); mdl_word(1'b1, w);
        check("R7 unlock on width change", 32'(lock), 0);
        check("R7 fresh double word", 32'(tx_data), 32'(w));
        for (int k = 0; k < 10; k++) begin
            tick(); mdl_word(1'b1, w);
            check("R2 double word", 32'(tx_data), 32'(w));
        end
        check("R8 double lock", 32'(lock), 1);
        check("R9 no errors double", 32'(err_cnt), 4);

        // Checker idle in toggle mode with a corrupted loop (R10).
        mode = 2'd2;
        err_mask = 20'h0F0F0;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R10 idle lock", 32'(lock), 0);
        end
        check("R10 idle err held", 32'(err_cnt), 4);
        err_mask = '0;

        // Self-synchronisation from a foreign phase (R8).
        mode = 2'd1; width_sel = 1'b0;
        rx_src = 1'b1; rx_drv = 20'h00155;
        tick();
        check("R7 restart after toggle", 32'(tx_data), 32'(w0));
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R8 garbage never locks", 32'(lock), 0);
        end
        mdl_reset();
        for (int i = 0; i < 37; i++) mh = {mh[5:0], mh[6] ^ mh[5]};
        for (int k = 0; k < 10; k++) begin
            mdl_word(1'b0, w);
            rx_drv = w;
            tick();
            if (k == 2) check("R8 foreign phase not yet", 32'(lock), 0);
            if (k == 3) check("R8 foreign phase locked", 32'(lock), 1);
        end
        check("R9 foreign stream clean", 32'(err_cnt), 4);

        // Saturation with every active lane inverted (R9).
        for (int k = 0; k < 6600; k++) begin
            mdl_word(1'b0, w);
            rx_drv = w ^ 20'h003FF;
            tick();
        end
        check("R9 saturated", 32'(err_cnt), 32'hFFFF);
        mdl_word(1'b0, w);
        rx_drv = w ^ 20'h00001;
        tick();
        check("R9 stays saturated", 32'(err_cnt), 32'hFFFF);

        report();
    end

endmodule